// File: doc/BRIEF.md
# Primary Data Cache Line Maintenance Unit

This block carries out one cache-maintenance command at a time on a single line of a primary data cache. A command is an opcode, a physical address and a one-cycle start strobe. The unit reads the addressed line's tag, valid and dirty state through a tag port and decides whether the line holds the address. It can write the line's doublewords back, reading them one at a time through a data port. It then writes the new line state back through the same tag port. The tag store and the data store belong to the surrounding cache and are not part of this block.

Three commands are supported. The first claims a line as dirty-exclusive for the new address without fetching any data. If a different dirty line is displaced, that line is written back first. The second invalidates a matching line and discards its data. The third writes a matching dirty line back and then invalidates it. A writeback goes to the secondary cache when one is present and to memory otherwise. Each doubleword carries SEC-DED check bits. For error-injection tests, software can corrupt the check bits of the addressed doubleword in a secondary-cache writeback by XOR with a register value.

Top module: `dcache_maint`

## Requirements
- R1: A create-dirty-exclusive command (op 0) on a line that is valid, dirty and holds a different tag writes that line back before the tag update. The writeback is LINE_DW beats, one per cycle, with doubleword index 0 upward. Beat k carries address {old tag, index, k, 3'b000} and the data read for that index and doubleword.
- R2: Every writeback beat of a command goes to the secondary cache (wb_l2_o = 1) when l2_present_i was 1 at the start strobe, and to memory (wb_l2_o = 0) otherwise.
- R3: A create-dirty-exclusive command always ends with a single tag write of valid = 1, dirty = 1 and the command's tag. No writeback happens when the old line is invalid, clean, or already holds the tag.
- R4: A hit-invalidate command (op 1) on a hit (valid and equal tag) writes valid = 0 and dirty = 0 with no writeback. On a miss it makes no tag write and no writeback.
- R5: A hit-writeback-invalidate command (op 2) on a dirty hit writes the line back and then writes valid = 0 and dirty = 0. On a clean hit it invalidates with no writeback. On a miss it changes nothing.
- R6: wb_ecc_o is a (72,64) SEC-DED code. Data bit d takes the d-th codeword position from 1 upward that is not a power of two. Check bit c (0..6) is the parity of the data bits whose position has bit c set. Bit 7 is the parity of all 64 data bits and the seven check bits.
- R7: ecc_xor_i is XORed into wb_ecc_o only when all of these hold: the beat goes to the secondary cache, ecc_en_i was 1 at the start strobe, and the beat's doubleword index equals paddr_i[3+:DW_SEL_W]. Every other beat carries plain check bits.
- R8: done_o is a one-cycle pulse. It comes one cycle after the tag write, or one cycle after the lookup when no tag write is made. hit_o gives the lookup result while done_o is high.
- R9: A start strobe while busy_o is 1 is ignored and does not queue a command. busy_o is 0 whenever no command is in progress, and no writeback or tag write occurs then.
- R10: Opcode 3 is reserved. It completes with done_o and makes no tag write and no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, taken only when idle |
| op_i | input | 2 | 0 create-dirty-exclusive, 1 hit-invalidate, 2 hit-writeback-invalidate, 3 reserved |
| paddr_i | input | ADDR_W | Physical address of the command |
| l2_present_i | input | 1 | Secondary cache is present |
| ecc_en_i | input | 1 | Enable for check-bit corruption |
| ecc_xor_i | input | 8 | Value XORed into the addressed doubleword's check bits |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command finished (one-cycle pulse) |
| hit_o | output | 1 | Lookup hit, valid with done_o |
| tag_idx_o | output | IDX_W | Line index for tag read and write |
| tag_valid_i | input | 1 | Valid bit read from the tag store |
| tag_dirty_i | input | 1 | Dirty bit read from the tag store |
| tag_i | input | TAG_W | Tag read from the tag store |
| tag_we_o | output | 1 | Tag store write enable |
| tag_valid_o | output | 1 | Valid bit to write |
| tag_dirty_o | output | 1 | Dirty bit to write |
| tag_o | output | TAG_W | Tag to write |
| data_idx_o | output | IDX_W | Line index for data read |
| data_dw_o | output | DW_SEL_W | Doubleword index for data read |
| data_i | input | 64 | Doubleword read from the data store (same cycle) |
| wb_valid_o | output | 1 | Writeback beat valid |
| wb_l2_o | output | 1 | Beat target: 1 secondary cache, 0 memory |
| wb_addr_o | output | ADDR_W | Beat address |
| wb_data_o | output | 64 | Beat data |
| wb_ecc_o | output | 8 | Beat check bits |

## Verification
The bench builds the unit with its defaults: 32-bit addresses, 16 sets and four doublewords per line. That gives a 23-bit tag and a 2-bit doubleword select. With four beats per line, an injected doubleword in the middle of the line can be told apart from the first and the last, so a wrong beat match shows up. Sixteen sets let each scenario use its own line in a bench-side tag model. A command that touches the wrong set therefore shows up as an unexpected change.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  typedef enum logic [1:0] {
    OP_CDE  = 2'd0,
    OP_HINV = 2'd1,
    OP_HWBI = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_WB,
    S_UPD,
    S_DONE
  } st_e;

  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;

  // data bits covered by Hamming check bit c
  function automatic logic [DATA_W-1:0] chk_mask(input int c);
    logic [DATA_W-1:0] m;
    int pos;
    m   = '0;
    pos = 0;
    for (int d = 0; d < DATA_W; d++) begin
      pos++;
      while ((pos & (pos - 1)) == 0) pos++;
      m[d] = ((pos >> c) & 1) == 1;
    end
    return m;
  endfunction
endpackage

// File: rtl/dcm_ecc.sv
module dcm_ecc
  import dcm_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  logic [CHK_W-2:0] ham;

  for (genvar c = 0; c < CHK_W - 1; c++) begin : g_ham
    localparam logic [DATA_W-1:0] MASK = chk_mask(c);
    assign ham[c] = ^(data_i & MASK);
  end

  assign chk_o = {(^data_i) ^ (^ham), ham};
endmodule

// File: rtl/dcm_ctrl.sv
module dcm_ctrl
  import dcm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_DW  = 4,
  parameter int IDX_W    = 4,
  parameter int DWS_W    = 2,
  parameter int TAG_W    = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic              l2_present_i,
  input  logic              ecc_en_i,
  input  logic              tag_valid_i,
  input  logic              tag_dirty_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DWS_W-1:0]  req_dw_o,
  output logic [DWS_W-1:0]  beat_o,
  output logic              wb_act_o,
  output logic [TAG_W-1:0]  vic_tag_o,
  output logic              l2_o,
  output logic              ecc_en_o,
  output logic              tag_we_o,
  output logic              tag_valid_o,
  output logic              tag_dirty_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              hit_o
);
  localparam int OFF_W = 3;
  localparam logic [DWS_W-1:0] LAST_BEAT = DWS_W'(LINE_DW - 1);

  st_e              st_q;
  op_e              op_q;
  logic [TAG_W-1:0] tag_q, vic_q;
  logic [IDX_W-1:0] idx_q;
  logic [DWS_W-1:0] dw_q, beat_q;
  logic             l2_q, een_q, hit_q;
  logic             hit;

  assign hit = tag_valid_i && (tag_i == tag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      op_q   <= OP_RSVD;
      tag_q  <= '0;
      vic_q  <= '0;
      idx_q  <= '0;
      dw_q   <= '0;
      beat_q <= '0;
      l2_q   <= 1'b0;
      een_q  <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          op_q  <= op_e'(op_i);
          tag_q <= paddr_i[ADDR_W-1 -: TAG_W];
          idx_q <= paddr_i[OFF_W+DWS_W +: IDX_W];
          dw_q  <= paddr_i[OFF_W +: DWS_W];
          l2_q  <= l2_present_i;
          een_q <= ecc_en_i;
          st_q  <= S_LOOK;
        end
        S_LOOK: begin
          hit_q  <= hit;
          vic_q  <= tag_i;
          beat_q <= '0;
          unique case (op_q)
            OP_CDE:  st_q <= (tag_valid_i && tag_dirty_i && !hit) ? S_WB : S_UPD;
            OP_HINV: st_q <= hit ? S_UPD : S_DONE;
            OP_HWBI: st_q <= hit ? (tag_dirty_i ? S_WB : S_UPD) : S_DONE;
            default: st_q <= S_DONE;
          endcase
        end
        S_WB: begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == LAST_BEAT) st_q <= S_UPD;
        end
        S_UPD:   st_q <= S_DONE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign idx_o       = idx_q;
  assign req_dw_o    = dw_q;
  assign beat_o      = beat_q;
  assign wb_act_o    = (st_q == S_WB);
  assign vic_tag_o   = vic_q;
  assign l2_o        = l2_q;
  assign ecc_en_o    = een_q;
  assign tag_we_o    = (st_q == S_UPD);
  // create-dirty-exclusive claims the line, both hit commands drop it
  assign tag_valid_o = (op_q == OP_CDE);
  assign tag_dirty_o = (op_q == OP_CDE);
  assign tag_o       = (op_q == OP_CDE) ? tag_q : vic_q;
  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = (st_q == S_DONE);
  assign hit_o       = hit_q;
endmodule

// File: rtl/dcm_wb_path.sv
module dcm_wb_path
  import dcm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int DWS_W  = 2,
  parameter int TAG_W  = 23
) (
  input  logic              wb_act_i,
  input  logic              l2_i,
  input  logic              ecc_en_i,
  input  logic [CHK_W-1:0]  ecc_xor_i,
  input  logic [DWS_W-1:0]  beat_i,
  input  logic [DWS_W-1:0]  req_dw_i,
  input  logic [TAG_W-1:0]  vic_tag_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic              wb_valid_o,
  output logic              wb_l2_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic [CHK_W-1:0]  wb_ecc_o
);
  logic inject;

  assign inject     = l2_i && ecc_en_i && (beat_i == req_dw_i);
  assign wb_valid_o = wb_act_i;
  assign wb_l2_o    = l2_i;
  assign wb_addr_o  = {vic_tag_i, idx_i, beat_i, 3'b000};
  assign wb_data_o  = data_i;
  assign wb_ecc_o   = inject ? (chk_i ^ ecc_xor_i) : chk_i;
endmodule

// File: rtl/dcache_maint.sv
module dcache_maint
  import dcm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SETS     = 16,
  parameter int LINE_DW  = 4,
  localparam int IDX_W    = $clog2(SETS),
  localparam int DW_SEL_W = $clog2(LINE_DW),
  localparam int TAG_W    = ADDR_W - IDX_W - DW_SEL_W - 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          op_i,
  input  logic [ADDR_W-1:0]   paddr_i,
  input  logic                l2_present_i,
  input  logic                ecc_en_i,
  input  logic [7:0]          ecc_xor_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                hit_o,
  output logic [IDX_W-1:0]    tag_idx_o,
  input  logic                tag_valid_i,
  input  logic                tag_dirty_i,
  input  logic [TAG_W-1:0]    tag_i,
  output logic                tag_we_o,
  output logic                tag_valid_o,
  output logic                tag_dirty_o,
  output logic [TAG_W-1:0]    tag_o,
  output logic [IDX_W-1:0]    data_idx_o,
  output logic [DW_SEL_W-1:0] data_dw_o,
  input  logic [63:0]         data_i,
  output logic                wb_valid_o,
  output logic                wb_l2_o,
  output logic [ADDR_W-1:0]   wb_addr_o,
  output logic [63:0]         wb_data_o,
  output logic [7:0]          wb_ecc_o
);
  logic [IDX_W-1:0]    idx;
  logic [DW_SEL_W-1:0] req_dw, beat;
  logic                wb_act, l2, een;
  logic [TAG_W-1:0]    vic_tag;
  logic [CHK_W-1:0]    chk;

  dcm_ctrl #(
    .ADDR_W (ADDR_W),
    .LINE_DW(LINE_DW),
    .IDX_W  (IDX_W),
    .DWS_W  (DW_SEL_W),
    .TAG_W  (TAG_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .op_i        (op_i),
    .paddr_i     (paddr_i),
    .l2_present_i(l2_present_i),
    .ecc_en_i    (ecc_en_i),
    .tag_valid_i (tag_valid_i),
    .tag_dirty_i (tag_dirty_i),
    .tag_i       (tag_i),
    .idx_o       (idx),
    .req_dw_o    (req_dw),
    .beat_o      (beat),
    .wb_act_o    (wb_act),
    .vic_tag_o   (vic_tag),
    .l2_o        (l2),
    .ecc_en_o    (een),
    .tag_we_o    (tag_we_o),
    .tag_valid_o (tag_valid_o),
    .tag_dirty_o (tag_dirty_o),
    .tag_o       (tag_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .hit_o       (hit_o)
  );

  dcm_ecc u_ecc (
    .data_i(data_i),
    .chk_o (chk)
  );

  dcm_wb_path #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W),
    .DWS_W (DW_SEL_W),
    .TAG_W (TAG_W)
  ) u_wb (
    .wb_act_i  (wb_act),
    .l2_i      (l2),
    .ecc_en_i  (een),
    .ecc_xor_i (ecc_xor_i),
    .beat_i    (beat),
    .req_dw_i  (req_dw),
    .vic_tag_i (vic_tag),
    .idx_i     (idx),
    .data_i    (data_i),
    .chk_i     (chk),
    .wb_valid_o(wb_valid_o),
    .wb_l2_o   (wb_l2_o),
    .wb_addr_o (wb_addr_o),
    .wb_data_o (wb_data_o),
    .wb_ecc_o  (wb_ecc_o)
  );

  assign tag_idx_o  = idx;
  assign data_idx_o = idx;
  assign data_dw_o  = beat;
endmodule

// File: rtl/dcache_maint_chk.sv
module dcache_maint_chk #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 23
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              tag_we_o,
  input logic              tag_valid_o,
  input logic              tag_dirty_o,
  input logic              wb_valid_o,
  input logic              wb_l2_o,
  input logic [ADDR_W-1:0] wb_addr_o
);
  p_beat_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && $past(wb_valid_o) |-> wb_addr_o == $past(wb_addr_o) + ADDR_W'(8));

  p_route_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && $past(wb_valid_o) |-> $stable(wb_l2_o));

  p_claim_dirty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we_o && tag_valid_o |-> tag_dirty_o);

  p_drop_clean_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we_o && !tag_valid_o |-> !tag_dirty_o);

  p_no_wb_during_upd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we_o |-> !wb_valid_o);

  p_done_after_we_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we_o |=> done_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !wb_valid_o && !tag_we_o && !done_o);
endmodule

bind dcache_maint dcache_maint_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/dcache_maint_tb.sv
module dcache_maint_tb;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 32;
  localparam int SETS   = 16;
  localparam int LDW    = 4;
  localparam int IDX_W  = 4;
  localparam int DWS_W  = 2;
  localparam int TAG_W  = ADDR_W - IDX_W - DWS_W - 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [ADDR_W-1:0] paddr = '0;
  logic l2p = 1'b0, een = 1'b0;
  logic [7:0] exor = 8'h00;
  logic busy, done, hit;
  logic [IDX_W-1:0] tidx, didx;
  logic [DWS_W-1:0] ddw;
  logic tv_i, td_i, twe, tv_o, td_o;
  logic [TAG_W-1:0] tg_i, tg_o;
  logic [63:0] dat;
  logic wbv, wbl2;
  logic [ADDR_W-1:0] wba;
  logic [63:0] wbd;
  logic [7:0] wbe;

  logic             m_v [SETS];
  logic             m_d [SETS];
  logic [TAG_W-1:0] m_t [SETS];

  int checks = 0, fails = 0, cyc = 0;
  int n_wb, we_cyc, done_cyc, n_we;
  logic done_seen, hit_cap;
  logic [ADDR_W-1:0] c_addr [8];
  logic [63:0]       c_data [8];
  logic [7:0]        c_ecc  [8];
  logic              c_l2   [8];

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [63:0] dfun(input int idx, input int dw);
    return {32'(idx) * 32'h0101_0101 ^ 32'hC0DE_0000 ^ 32'(dw),
            32'h9E37_79B9 * 32'(idx * 8 + dw + 1)};
  endfunction

  function automatic logic [7:0] ref_ecc(input logic [63:0] d);
    logic [71:0] cw;
    logic [7:0]  r;
    int p, k;
    cw = '0;
    p  = 1;
    k  = 0;
    while (k < 64) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[k];
        k++;
      end
      p++;
    end
    r = '0;
    for (int c = 0; c < 7; c++)
      for (int q = 1; q < 72; q++)
        if (((q >> c) & 1) == 1 && (q & (q - 1)) != 0) r[c] = r[c] ^ cw[q];
    r[7] = (^d) ^ (^r[6:0]);
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] mk(input logic [TAG_W-1:0] t, input int idx, input int dw);
    return {t, 4'(idx), 2'(dw), 3'b000};
  endfunction

  assign tv_i = m_v[tidx];
  assign td_i = m_d[tidx];
  assign tg_i = m_t[tidx];
  assign dat  = dfun(int'(didx), int'(ddw));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (twe) begin
      m_v[tidx] <= tv_o;
      m_d[tidx] <= td_o;
      m_t[tidx] <= tg_o;
    end
  end

  always @(negedge clk) begin
    if (wbv) begin
      if (n_wb < 8) begin
        c_addr[n_wb] = wba;
        c_data[n_wb] = wbd;
        c_ecc[n_wb]  = wbe;
        c_l2[n_wb]   = wbl2;
      end
      n_wb++;
    end
    if (twe) begin
      we_cyc = cyc;
      n_we++;
    end
    if (done) begin
      done_cyc  = cyc;
      done_seen = 1'b1;
      hit_cap   = hit;
    end
  end

  dcache_maint #(.ADDR_W(ADDR_W), .SETS(SETS), .LINE_DW(LDW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .paddr_i(paddr),
    .l2_present_i(l2p), .ecc_en_i(een), .ecc_xor_i(exor),
    .busy_o(busy), .done_o(done), .hit_o(hit),
    .tag_idx_o(tidx), .tag_valid_i(tv_i), .tag_dirty_i(td_i), .tag_i(tg_i),
    .tag_we_o(twe), .tag_valid_o(tv_o), .tag_dirty_o(td_o), .tag_o(tg_o),
    .data_idx_o(didx), .data_dw_o(ddw), .data_i(dat),
    .wb_valid_o(wbv), .wb_l2_o(wbl2), .wb_addr_o(wba), .wb_data_o(wbd), .wb_ecc_o(wbe)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_line(input int idx, input logic v, input logic d, input logic [TAG_W-1:0] t);
    m_v[idx] = v;
    m_d[idx] = d;
    m_t[idx] = t;
  endtask

  // inject: pulse a second start two cycles into the command
  task automatic run_cmd(input logic [1:0] o, input logic [ADDR_W-1:0] a, input logic inject,
                         input logic [ADDR_W-1:0] a2);
    n_wb = 0; n_we = 0; we_cyc = -1; done_cyc = -1; done_seen = 1'b0; hit_cap = 1'b0;
    @(negedge clk);
    start = 1'b1; op = o; paddr = a;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      @(negedge clk);
      start = 1'b1; op = 2'd0; paddr = a2;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 40 && !done_seen; i++) begin
      @(negedge clk);
      #1;
    end
    chk(done_seen, "R8 command completes", 64'(done_seen), 64'd1);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !wbv && !twe, "R9 reset idle", {busy, done, wbv, twe}, 4'b0000);
  endtask

  task automatic t_cde_victim(input logic l2, input logic en, input int idx, input int rdw);
    logic [TAG_W-1:0] old_t, new_t;
    logic [7:0] e;
    old_t = 23'h011111 + TAG_W'(idx);
    new_t = 23'h022222 + TAG_W'(idx);
    set_line(idx, 1'b1, 1'b1, old_t);
    l2p = l2; een = en; exor = 8'hA7;
    run_cmd(2'd0, mk(new_t, idx, rdw), 1'b0, '0);
    l2p = 1'b0; een = 1'b0;
    chk(n_wb == LDW, "R1 victim beat count", 64'(n_wb), 64'(LDW));
    for (int k = 0; k < LDW; k++) begin
      chk(c_addr[k] == mk(old_t, idx, k), "R1 beat address", 64'(c_addr[k]), 64'(mk(old_t, idx, k)));
      chk(c_data[k] == dfun(idx, k), "R1 beat data", c_data[k], dfun(idx, k));
      chk(c_l2[k] == l2, "R2 writeback target", 64'(c_l2[k]), 64'(l2));
      e = ref_ecc(dfun(idx, k));
      if (l2 && en && k == rdw) e = e ^ 8'hA7;
      chk(c_ecc[k] == e, "R6 R7 beat check bits", 64'(c_ecc[k]), 64'(e));
    end
    chk(m_v[idx] && m_d[idx] && m_t[idx] == new_t, "R3 claimed line",
        {m_v[idx], m_d[idx], 41'(m_t[idx])}, {1'b1, 1'b1, 41'(new_t)});
    chk(done_cyc == we_cyc + 1, "R8 done after tag write", 64'(done_cyc), 64'(we_cyc + 1));
  endtask

  task automatic t_cde_nowb;
    set_line(1, 1'b0, 1'b1, 23'h000ABC);
    run_cmd(2'd0, mk(23'h000123, 1, 0), 1'b0, '0);
    chk(n_wb == 0 && m_v[1] && m_d[1] && m_t[1] == 23'h000123, "R3 invalid victim",
        64'(n_wb), 64'd0);
    set_line(2, 1'b1, 1'b0, 23'h000ABC);
    run_cmd(2'd0, mk(23'h000456, 2, 3), 1'b0, '0);
    chk(n_wb == 0 && m_v[2] && m_d[2] && m_t[2] == 23'h000456, "R3 clean victim",
        64'(n_wb), 64'd0);
    set_line(4, 1'b1, 1'b1, 23'h000777);
    run_cmd(2'd0, mk(23'h000777, 4, 1), 1'b0, '0);
    chk(n_wb == 0 && n_we == 1 && m_v[4] && m_d[4] && hit_cap, "R3 hit no writeback",
        {n_wb[31:0], n_we[31:0]}, {32'd0, 32'd1});
  endtask

  task automatic t_hinv;
    set_line(6, 1'b1, 1'b1, 23'h003333);
    run_cmd(2'd1, mk(23'h003333, 6, 0), 1'b0, '0);
    chk(n_wb == 0 && !m_v[6] && !m_d[6] && hit_cap, "R4 hit invalidate",
        {n_wb[31:0], 30'd0, m_v[6], m_d[6]}, 64'd0);
    set_line(6, 1'b1, 1'b1, 23'h003333);
    run_cmd(2'd1, mk(23'h004444, 6, 0), 1'b0, '0);
    chk(n_wb == 0 && n_we == 0 && m_v[6] && m_d[6] && m_t[6] == 23'h003333 && !hit_cap,
        "R4 miss unchanged", 64'(n_we), 64'd0);
    set_line(6, 1'b0, 1'b0, 23'h003333);
    run_cmd(2'd1, mk(23'h003333, 6, 0), 1'b0, '0);
    chk(n_we == 0 && !hit_cap, "R4 invalid line is a miss", 64'(n_we), 64'd0);
  endtask

  task automatic t_hwbi;
    logic [7:0] e;
    set_line(5, 1'b1, 1'b1, 23'h005555);
    l2p = 1'b1; een = 1'b1; exor = 8'h5A;
    run_cmd(2'd2, mk(23'h005555, 5, 2), 1'b0, '0);
    l2p = 1'b0; een = 1'b0;
    chk(n_wb == LDW, "R5 dirty hit writes back", 64'(n_wb), 64'(LDW));
    for (int k = 0; k < LDW; k++) begin
      e = ref_ecc(dfun(5, k)) ^ ((k == 2) ? 8'h5A : 8'h00);
      chk(c_ecc[k] == e && c_addr[k] == mk(23'h005555, 5, k), "R7 injected doubleword only",
          64'(c_ecc[k]), 64'(e));
    end
    chk(!m_v[5] && !m_d[5] && done_cyc == we_cyc + 1, "R5 invalidated after writeback",
        {m_v[5], m_d[5]}, 2'b00);
    set_line(10, 1'b1, 1'b0, 23'h00AAAA);
    run_cmd(2'd2, mk(23'h00AAAA, 10, 0), 1'b0, '0);
    chk(n_wb == 0 && !m_v[10], "R5 clean hit", 64'(n_wb), 64'd0);
    set_line(11, 1'b1, 1'b1, 23'h00BBBB);
    run_cmd(2'd2, mk(23'h00CCCC, 11, 0), 1'b0, '0);
    chk(n_wb == 0 && n_we == 0 && m_v[11] && m_d[11] && m_t[11] == 23'h00BBBB,
        "R5 miss unchanged", 64'(n_wb), 64'd0);
  endtask

  task automatic t_rsvd;
    set_line(7, 1'b1, 1'b1, 23'h007070);
    run_cmd(2'd3, mk(23'h007070, 7, 0), 1'b0, '0);
    chk(n_wb == 0 && n_we == 0 && m_v[7] && m_d[7] && m_t[7] == 23'h007070,
        "R10 reserved op", {n_wb[31:0], n_we[31:0]}, 64'd0);
  endtask

  task automatic t_busy;
    set_line(8, 1'b1, 1'b1, 23'h008888);
    set_line(9, 1'b0, 1'b0, 23'h000000);
    run_cmd(2'd2, mk(23'h008888, 8, 0), 1'b1, mk(23'h009999, 9, 0));
    chk(n_wb == LDW && !m_v[8], "R9 first command runs", 64'(n_wb), 64'(LDW));
    repeat (4) @(negedge clk);
    chk(!busy && !m_v[9] && n_we == 1, "R9 start while busy ignored",
        {busy, m_v[9]}, 2'b00);
  endtask

  initial begin
    for (int i = 0; i < SETS; i++) set_line(i, 1'b0, 1'b0, '0);
    n_wb = 0; n_we = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_cde_victim(1'b1, 1'b0, 3, 1);
    t_cde_victim(1'b0, 1'b1, 12, 0);
    t_cde_victim(1'b1, 1'b1, 13, 3);
    t_cde_nowb();
    t_hinv();
    t_hwbi();
    t_rsvd();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule